// File: doc/BRIEF.md
# Prescaled Two-Channel PWM Timer with Write-Completion Flags

This block generates up to two pulse-width-modulated outputs from one shared up-counter. The counter is clocked through a power-of-two prescaler and wraps after a programmable reload value. Each channel compares the counter against its own threshold and drives an output whose idle and active levels follow a per-channel polarity bit. A small word-wide register bus (write strobe, address, write data, combinational read data) sets up the timer.

The register writes follow strict rules. The prescaler may be changed only while the timer is stopped. The reload and threshold values may be changed only while the timer is enabled. Every accepted reload or threshold write raises a sticky completion flag that software polls and then clears with a write-one-to-clear register. Channel-mode writes are rate-limited: after one is accepted, further ones are refused for three prescaled ticks. Polarity is taken only while the channel is off.

Software programs threshold = period_ticks − 1 − active_ticks and reload = period_ticks − 1. It then sets the enable bit and, in a later write, the start bit.

Top module: `lpt_pwm_timer`

## Requirements
- R1: The configuration register (address 1) holds the prescale exponent P in bits [2:0]. The counter advances once every 2^P clock cycles, for P from 0 to 7.
- R2: A write to the configuration register while the enable bit is set leaves it unchanged. A write while the enable bit is clear is stored and reads back.
- R3: Writes to the reload register (address 2) or to a threshold register (address 3 for channel 0, address 4 for channel 1) while the timer is disabled leave the register unchanged and raise no flag.
- R4: An accepted reload or threshold write sets its flag in the status register (address 6): bit 0 for reload, bit 1 for channel 0, bit 2 for channel 1. The flag is visible after the second rising edge counted from the edge that takes the write, and stays set until it is cleared.
- R5: Writing a 1 to bit i of the clear register (address 7) resets status flag i. If a flag is being set in the same cycle, the set wins.
- R6: While running, the counter steps 0, 1, …, reload and then returns to 0. One period is therefore (reload+1)·2^P clock cycles.
- R7: While running with the channel enabled, the raw output is active for the counter values above the threshold, which gives (reload−threshold)·2^P active cycles per period. The pin carries the raw output XOR the channel polarity.
- R8: In the control register (address 0), bit 0 is enable and bit 1 is start. Start takes effect only if enable is already set. Clearing enable stops the timer and zeroes the counter. A read returns {running, enable} in bits [1:0].
- R9: In the channel-mode register (address 5), channel n has its enable in bit 2n and its polarity in bit 2n+1. A new polarity is taken only if that channel's enable was clear before the write.
- R10: After an accepted channel-mode write, further channel-mode writes are ignored until 3·2^P clock cycles have elapsed. A write exactly 3·2^P cycles later is accepted.
- R11: While the timer is not running, or a channel is disabled, that channel's pin sits at its inactive level, which equals its polarity bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Timer and bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| pwm_o | output | 2 | PWM outputs, one per channel |

## Verification
A completion flag can be raised by a pending reload or threshold write in the same cycle that software writes its clear bit. The bench provokes this by writing the reload register and then the clear register on the very next edge, which lands the clear on the edge where the flag sets. The status read that follows must show the flag still set, and a second, lone clear must remove it. The same kind of coincidence appears in the channel-mode guard: a write one cycle before the guard expires must be refused, and a write on the expiry cycle must be taken.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_CFG    = 3'd1,
    A_RELOAD = 3'd2,
    A_THR0   = 3'd3,
    A_THR1   = 3'd4,
    A_CHMODE = 3'd5,
    A_STATUS = 3'd6,
    A_CLEAR  = 3'd7
  } lpt_addr_e;
endpackage

// File: rtl/lpt_prescaler.sv
module lpt_prescaler #(
  parameter int PSC_W = 3,
  localparam int DIV_W = (1 << PSC_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PSC_W-1:0] shift_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] div_q, div_d, mask;

  assign mask   = ~({DIV_W{1'b1}} << shift_i);
  assign tick_o = run_i && (div_q == mask);

  always_comb begin
    div_d = div_q;
    if (!run_i)      div_d = '0;
    else if (tick_o) div_d = '0;
    else             div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_d;
  end
endmodule

// File: rtl/lpt_counter.sv
module lpt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)                cnt_d = '0;
    else if (tick_i) begin
      if (cnt_q >= reload_i)   cnt_d = '0;
      else                     cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/lpt_chan_out.sv
module lpt_chan_out #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             chen_i,
  input  logic             pol_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic             pwm_o
);
  logic pwm_q, pwm_d, active;

  assign active = run_i && chen_i && (cnt_i > thr_i);
  assign pwm_d  = active ^ pol_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwm_q <= 1'b0;
    else         pwm_q <= pwm_d;
  end

  assign pwm_o = pwm_q;
endmodule

// File: rtl/lpt_wr_guard.sv
module lpt_wr_guard #(
  parameter int PSC_W = 3,
  localparam int GUARD_W = (1 << PSC_W) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic [PSC_W-1:0] shift_i,
  output logic             busy_o
);
  logic [GUARD_W-1:0] guard_q, guard_d;

  always_comb begin
    guard_d = guard_q;
    if (accept_i)            guard_d = (GUARD_W'(3) << shift_i) - 1'b1;
    else if (guard_q != '0)  guard_d = guard_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) guard_q <= '0;
    else         guard_q <= guard_d;
  end

  assign busy_o = (guard_q != '0);
endmodule

// File: rtl/lpt_pwm_timer.sv
module lpt_pwm_timer
  import lpt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 3,
  parameter int NCH   = 2,
  localparam int NFLAG = NCH + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [2:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic [NCH-1:0]   pwm_o
);
  logic [1:0] rsync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsync_q <= '0;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n = rsync_q[1];

  logic                       en_q, en_d, run_q, run_d;
  logic [PSC_W-1:0]           psc_q, psc_d;
  logic [CNT_W-1:0]           reload_q, reload_d;
  logic [NCH-1:0][CNT_W-1:0]  thr_q, thr_d;
  logic [NCH-1:0]             chen_q, chen_d, pol_q, pol_d;
  logic [NFLAG-1:0]           pend_q, pend_d, flag_q, flag_d;
  logic                       tick, guard_busy, chmode_ok;
  logic [CNT_W-1:0]           cnt;

  logic wr_ctrl, wr_cfg, wr_reload, wr_chmode, wr_clear;
  assign wr_ctrl   = wr_i && (addr_i == A_CTRL);
  assign wr_cfg    = wr_i && (addr_i == A_CFG);
  assign wr_reload = wr_i && (addr_i == A_RELOAD);
  assign wr_chmode = wr_i && (addr_i == A_CHMODE);
  assign wr_clear  = wr_i && (addr_i == A_CLEAR);
  assign chmode_ok = wr_chmode && !guard_busy;

  always_comb begin
    en_d     = en_q;
    run_d    = run_q;
    psc_d    = psc_q;
    reload_d = reload_q;
    thr_d    = thr_q;
    chen_d   = chen_q;
    pol_d    = pol_q;
    pend_d   = '0;
    if (wr_ctrl) begin
      en_d  = wdata_i[0];
      run_d = wdata_i[0] && (run_q || (en_q && wdata_i[1]));
    end
    if (wr_cfg && !en_q) psc_d = wdata_i[PSC_W-1:0];
    if (wr_reload && en_q) begin
      reload_d  = wdata_i;
      pend_d[0] = 1'b1;
    end
    for (int n = 0; n < NCH; n++) begin
      if (wr_i && (addr_i == 3'(A_THR0 + n)) && en_q) begin
        thr_d[n]    = wdata_i;
        pend_d[n+1] = 1'b1;
      end
      if (chmode_ok) begin
        chen_d[n] = wdata_i[2*n];
        if (!chen_q[n]) pol_d[n] = wdata_i[2*n+1];
      end
    end
    for (int i = 0; i < NFLAG; i++)
      flag_d[i] = pend_q[i] || (flag_q[i] && !(wr_clear && wdata_i[i]));
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      run_q    <= 1'b0;
      psc_q    <= '0;
      reload_q <= '0;
      thr_q    <= '0;
      chen_q   <= '0;
      pol_q    <= '0;
      pend_q   <= '0;
      flag_q   <= '0;
    end else begin
      en_q     <= en_d;
      run_q    <= run_d;
      psc_q    <= psc_d;
      reload_q <= reload_d;
      thr_q    <= thr_d;
      chen_q   <= chen_d;
      pol_q    <= pol_d;
      pend_q   <= pend_d;
      flag_q   <= flag_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:   rdata_o[1:0] = {run_q, en_q};
      A_CFG:    rdata_o[PSC_W-1:0] = psc_q;
      A_RELOAD: rdata_o = reload_q;
      A_CHMODE: for (int n = 0; n < NCH; n++) rdata_o[2*n +: 2] = {pol_q[n], chen_q[n]};
      A_STATUS: rdata_o[NFLAG-1:0] = flag_q;
      default: begin
        for (int n = 0; n < NCH; n++)
          if (addr_i == 3'(A_THR0 + n)) rdata_o = thr_q[n];
      end
    endcase
  end

  lpt_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk_i(clk_i), .rst_ni(rst_n), .run_i(run_q), .shift_i(psc_q), .tick_o(tick)
  );

  lpt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_n), .run_i(run_q), .tick_i(tick),
    .reload_i(reload_q), .cnt_o(cnt)
  );

  lpt_wr_guard #(.PSC_W(PSC_W)) u_guard (
    .clk_i(clk_i), .rst_ni(rst_n), .accept_i(chmode_ok), .shift_i(psc_q), .busy_o(guard_busy)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    lpt_chan_out #(.CNT_W(CNT_W)) u_out (
      .clk_i(clk_i), .rst_ni(rst_n), .run_i(run_q), .chen_i(chen_q[g]),
      .pol_i(pol_q[g]), .cnt_i(cnt), .thr_i(thr_q[g]), .pwm_o(pwm_o[g])
    );
  end
endmodule

// File: rtl/lpt_pwm_timer_chk.sv
module lpt_pwm_timer_chk #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 3,
  parameter int NCH   = 2
) (
  input logic                      clk_i,
  input logic                      rst_n,
  input logic                      wr_i,
  input logic [2:0]                addr_i,
  input logic [CNT_W-1:0]          wdata_i,
  input logic                      en_q,
  input logic                      run_q,
  input logic [PSC_W-1:0]          psc_q,
  input logic [CNT_W-1:0]          reload_q,
  input logic [CNT_W-1:0]          cnt,
  input logic                      tick,
  input logic [NCH-1:0]            chen_q,
  input logic [NCH-1:0]            pol_q,
  input logic [NCH:0]              flag_q,
  input logic [NCH:0]              pend_q,
  input logic                      guard_busy,
  input logic [NCH-1:0]            pwm_o
);
  a_r2_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_n)
    en_q |=> $stable(psc_q));

  a_r3_reload_frozen: assert property (@(posedge clk_i) disable iff (!rst_n)
    !en_q |=> $stable(reload_q));

  a_r4_reload_flag: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_i && addr_i == 3'd2 && en_q) |-> ##2 flag_q[0]);

  a_r5_clear_flag: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_i && addr_i == 3'd7 && wdata_i[0] && !pend_q[0]) |=> !flag_q[0]);

  a_r6_wrap: assert property (@(posedge clk_i) disable iff (!rst_n)
    (run_q && tick && cnt >= reload_q) |=> (cnt == '0));

  a_r8_stop_zero: assert property (@(posedge clk_i) disable iff (!rst_n)
    !en_q |=> (cnt == '0) && !run_q);

  a_r10_guard: assert property (@(posedge clk_i) disable iff (!rst_n)
    guard_busy |=> $stable(chen_q));

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    a_r9_pol_locked: assert property (@(posedge clk_i) disable iff (!rst_n)
      chen_q[n] |=> $stable(pol_q[n]));
    a_r11_idle_level: assert property (@(posedge clk_i) disable iff (!rst_n)
      (!run_q || !chen_q[n]) |=> (pwm_o[n] == $past(pol_q[n])));
  end
endmodule

bind lpt_pwm_timer lpt_pwm_timer_chk #(.CNT_W(CNT_W), .PSC_W(PSC_W), .NCH(NCH)) u_chk (
  .clk_i(clk_i), .rst_n(rst_n), .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .en_q(en_q), .run_q(run_q), .psc_q(psc_q), .reload_q(reload_q), .cnt(cnt),
  .tick(tick), .chen_q(chen_q), .pol_q(pol_q), .flag_q(flag_q), .pend_q(pend_q),
  .guard_busy(guard_busy), .pwm_o(pwm_o)
);

// File: tb/lpt_pwm_timer_tb.sv
`timescale 1ns/1ps
module lpt_pwm_timer_tb;
  localparam logic [2:0] CTRL = 3'd0, CFG = 3'd1, RLD = 3'd2, THR0 = 3'd3,
                         THR1 = 3'd4, CHM = 3'd5, STAT = 3'd6, CLR = 3'd7;

  logic        clk = 1'b0, rst_ni = 1'b0, wr_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  wire  [15:0] rdata_o;
  wire  [1:0]  pwm_o;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  lpt_pwm_timer u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pwm_o(pwm_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    wr_i = 1'b1; addr_i = a; wdata_i = 16'(d);
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    addr_i = a;
    #0.5;
    v = int'(rdata_o);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int exp_active(int r, int c, int p, int k);
    return (r - c) * (1 << p) * k;
  endfunction

  task automatic measure(input int ch, input int pol, input int len, output int n);
    n = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if ((pwm_o[ch] ^ pol[0]) == 1'b1) n++;
    end
  endtask

  task automatic setup(input int p, input int r, input int c0, input int c1,
                       input int p0, input int p1);
    wr(CTRL, 0); wr(CFG, p); wr(CTRL, 1);
    wr(RLD, r); wr(THR0, c0); wr(THR1, c1);
    idle(400); wr(CHM, (p0 << 1) | (p1 << 3));
    idle(400); wr(CHM, (p0 << 1) | (p1 << 3) | 5);
    wr(CTRL, 3);
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int v, n;
    void'($urandom(32'd1234));
    idle(3);
    rst_ni = 1'b1;
    idle(4);

    // reset state
    rd(CTRL, v); chk("reset ctrl R8", v, 0);
    rd(STAT, v); chk("reset status R4", v, 0);
    chk("reset pins R11", int'(pwm_o), 0);

    // R3: writes while disabled ignored
    wr(RLD, 9); wr(THR1, 5); idle(2);
    rd(RLD, v); chk("R3 reload ignored", v, 0);
    rd(THR1, v); chk("R3 thr ignored", v, 0);
    rd(STAT, v); chk("R3 no flag", v, 0);

    // R8 / R2
    wr(CTRL, 1); rd(CTRL, v); chk("R8 enable only", v, 1);
    wr(CFG, 5); rd(CFG, v); chk("R2 cfg locked", v, 0);
    wr(CTRL, 0); wr(CFG, 5); rd(CFG, v); chk("R2 cfg open", v, 5);
    wr(CFG, 0); wr(CTRL, 3); rd(CTRL, v); chk("R8 start needs enable", v, 1);
    wr(CTRL, 3); rd(CTRL, v); chk("R8 running", v, 3);

    // R4 flag timing
    wr(THR1, 4); rd(STAT, v); chk("R4 not yet", v, 0);
    idle(1); rd(STAT, v); chk("R4 flag ch1", v, 4);
    // R5 clear and set-wins collision
    wr(CLR, 4); rd(STAT, v); chk("R5 cleared", v, 0);
    wr(RLD, 7); wr(CLR, 1); rd(STAT, v); chk("R5 set wins", v, 1);
    wr(CLR, 1); rd(STAT, v); chk("R5 clear after", v, 0);

    // R10 guard with P=1 (3*2 = 6 cycles)
    wr(CTRL, 0); wr(CFG, 1); idle(400);
    wr(CHM, 0); idle(4);
    wr(CHM, 5); rd(CHM, v); chk("R10 early refused", v, 0);
    wr(CHM, 5); rd(CHM, v); chk("R10 on time", v, 5);

    // R9 polarity lock
    idle(400); wr(CHM, 15); rd(CHM, v); chk("R9 pol locked", v, 5);
    idle(400); wr(CHM, 10); rd(CHM, v); chk("R9 disable keeps pol", v, 0);
    idle(400); wr(CHM, 10); rd(CHM, v); chk("R9 pol taken", v, 10);

    // R1 maximum prescale
    setup(7, 3, 1, 2, 0, 0);
    measure(0, 0, 512, n); chk("R1 ch0 P=7", n, exp_active(3, 1, 7, 1));
    measure(1, 0, 512, n); chk("R1 ch1 P=7", n, exp_active(3, 2, 7, 1));

    // R11 stop drives idle level
    setup(0, 9, 4, 4, 1, 0);
    wr(CTRL, 0); idle(1);
    rd(CTRL, v); chk("R8 stopped", v, 0);
    n = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (pwm_o != 2'b01) n++;
    end
    chk("R11 idle levels", n, 0);

    // R11 channel disable while running
    setup(0, 9, 0, 0, 0, 0);
    idle(400); wr(CHM, 4); idle(1);
    measure(0, 0, 10, n); chk("R11 ch0 off", n, 0);
    measure(1, 0, 10, n); chk("R7 ch1 still on", n, 9);

    // R6/R7 random patterns
    for (int it = 0; it < 8; it++) begin
      int p, r, c0, c1, q0, q1;
      p  = int'($urandom_range(0, 3));
      r  = int'($urandom_range(2, 30));
      c0 = int'($urandom_range(0, r));
      c1 = int'($urandom_range(0, r));
      q0 = int'($urandom_range(0, 1));
      q1 = int'($urandom_range(0, 1));
      setup(p, r, c0, c1, q0, q1);
      measure(0, q0, (r + 1) * (1 << p), n); chk("R7 ch0 duty", n, exp_active(r, c0, p, 1));
      measure(1, q1, (r + 1) * (1 << p), n); chk("R7 ch1 duty", n, exp_active(r, c1, p, 1));
      measure(0, q0, 2 * (r + 1) * (1 << p), n); chk("R6 two periods", n, exp_active(r, c0, p, 2));
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule